// File: doc/BRIEF.md
# Circular-Buffer Word DMA Channel with Address Modulo

This block is one DMA channel that streams 32-bit words from a circular buffer in memory into a single peripheral data register. The peripheral asks for data with a request pulse, and each accepted request moves one burst (a minor loop) of a configured number of bytes. A counted group of minor loops forms a major loop. When the last minor loop of a major loop finishes, the channel raises a one-cycle interrupt, reloads its counts and stays armed. Nothing in software has to reload the source address.

The source address wraps inside a power-of-two window. The window's size is set by a modulo field, and the buffer must be aligned to that size. Only the low bits of the address change, so the channel reads the buffer round and round. A position output advances by one major loop's worth of bytes at each major completion and wraps at the window size, so software can tell how far playback has come. The descriptor arrives on static configuration inputs. These inputs are sampled while the channel is armed and must be held stable from arming until the channel is off again.

The controller is a four-state machine. OFF means disarmed. IDLE means armed and waiting for a request. READ issues a memory read. WRITE hands the returned word to the peripheral. The transitions are:
- arm: OFF to IDLE when the enable input is high.
- disarm: IDLE to OFF when the enable input is low.
- start: IDLE to READ on a request.
- beat: READ to WRITE.
- next beat: WRITE to READ, inside a minor loop.
- chain: WRITE to READ, after the last beat of a minor loop when a request is pending or arriving.
- rest: WRITE to IDLE, after the last beat with no request.
- stop: WRITE to OFF, after the last beat with the enable input low.

Top module: `circ_dma_chan`

## Requirements
- R1: After reset, mem_rd_en, per_wr_en and irq are 0 and pos is 0. While the channel is off, requests start no read.
- R2: Each accepted request performs cfg_minor_bytes/4 beats. A beat is one cycle with mem_rd_en high, then one cycle with per_wr_en high. During the write cycle, per_wdata carries the word that memory returned for the preceding read.
- R3: After every beat the destination address advances by the signed cfg_doff. A value of 0 writes every word to the same register.
- R4: After every beat the source address advances by the signed cfg_soff. With cfg_smod = k > 0, address bits k and above stay equal to cfg_src_base and only bits k-1..0 change and wrap. With cfg_smod = 0 the sum is not wrapped. cfg_src_base must be aligned to 2^k.
- R5: irq is high for exactly one cycle. That cycle directly follows the write cycle that ends minor loop number cfg_major_cnt of a major loop.
- R6: At major completion the minor and major counts reload, and the source and destination addresses continue from where they were. The channel keeps serving requests with no rearm.
- R7: At each major completion, pos becomes (pos + cfg_minor_bytes*cfg_major_cnt) mod 2^cfg_smod. For cfg_smod = 0 the sum is not wrapped. The new value is visible in the same cycle as irq.
- R8: A request that arrives during a minor loop is held as one pending request. Further requests merge into it. A pending request, or a request in the last write cycle, starts the next minor loop's read in the very next cycle.
- R9: When enable rises in OFF, the channel loads the source base, destination address and counts, and clears pos. When enable falls, the minor loop in progress completes and the channel goes OFF. A pending request is dropped and no new loop starts.
- R10: A request while IDLE produces the first read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable: arms on rise; stops after current minor loop when low |
| req | input | 1 | Peripheral request, one minor loop per accepted request |
| cfg_src_base | input | ADDR_W | Start of the circular buffer, aligned to 2^cfg_smod |
| cfg_dst_addr | input | ADDR_W | Peripheral data register address |
| cfg_soff | input | OFF_W | Signed source step per beat |
| cfg_doff | input | OFF_W | Signed destination step per beat |
| cfg_minor_bytes | input | MINOR_W | Bytes moved per request (multiple of 4, nonzero) |
| cfg_major_cnt | input | MAJOR_W | Minor loops per major loop (nonzero) |
| cfg_smod | input | MOD_W | Source modulo: number of low address bits that change; 0 disables |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd_en |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_addr | output | ADDR_W | Peripheral write address |
| per_wdata | output | DATA_W | Peripheral write data |
| irq | output | 1 | Major-loop completion pulse |
| pos | output | ADDR_W | Buffer read position in bytes |

## Verification
Two of the block's functions can fall in the same cycle. One is a new request landing on the final write of a minor loop, which has to chain straight into the next read. The other is that same final write also closing a major loop, which must fire irq, reload the counts and move pos in one step. Random request pulses hit the last-write cycle often with short loops and tiny windows. A long run with the request held high forces every minor boundary, and every major boundary, to coincide with a live request. A cycle model built from the requirements predicts the strobe, address, data, irq and pos of every cycle, so a missing or extra idle cycle at a boundary shows up as a miscompare.

// File: rtl/circ_dma_pkg.sv
package circ_dma_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } chan_state_e;

endpackage

// File: rtl/dma_addr_step.sv
// Next-address generator: signed step, optionally confined to a 2^mod window.
module dma_addr_step #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 16,
    parameter int MOD_W   = 5,
    parameter bit USE_MOD = 1'b1
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [OFF_W-1:0]  step,
    input  logic [MOD_W-1:0]  mod_bits,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] sum;

    assign sum = cur + {{(ADDR_W-OFF_W){step[OFF_W-1]}}, step};

    generate
        if (USE_MOD) begin : g_window
            logic [ADDR_W-1:0] keep;
            assign keep = {ADDR_W{1'b1}} << mod_bits;
            assign nxt  = (mod_bits == '0) ? sum : ((cur & keep) | (sum & ~keep));
        end else begin : g_linear
            logic unused_mod;
            assign unused_mod = ^mod_bits;
            assign nxt        = sum;
        end
    endgenerate

endmodule

// File: rtl/dma_loop_ctr.sv
// Beat counter inside a minor loop and minor-loop counter inside a major loop.
module dma_loop_ctr #(
    parameter int MINOR_W = 16,
    parameter int MAJOR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [MINOR_W-1:0] cfg_beats,
    input  logic [MAJOR_W-1:0] cfg_major,
    output logic               last_beat,
    output logic               last_minor
);

    logic [MINOR_W-1:0] beat_left;
    logic [MAJOR_W-1:0] major_left;

    assign last_beat  = (beat_left == MINOR_W'(1));
    assign last_minor = (major_left == MAJOR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_left  <= '0;
            major_left <= '0;
        end else if (load) begin
            beat_left  <= cfg_beats;
            major_left <= cfg_major;
        end else if (step) begin
            if (last_beat) begin
                beat_left  <= cfg_beats;
                major_left <= last_minor ? cfg_major : major_left - 1'b1;
            end else begin
                beat_left  <= beat_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_chan_fsm.sv
// Channel controller: OFF / IDLE / READ / WRITE with one pending-request flag.
module dma_chan_fsm
    import circ_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic last_beat,
    output logic arm,
    output logic rd_en,
    output logic wr_en
);

    chan_state_e st_q, st_d;
    logic        pend_q, pend_d;

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        unique case (st_q)
            ST_OFF: begin
                if (en) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en)      st_d = ST_OFF;
                else if (req) st_d = ST_READ;
            end
            ST_READ: begin
                pend_d = en & (pend_q | req);
                st_d   = ST_WRITE;
            end
            ST_WRITE: begin
                if (last_beat) begin
                    pend_d = 1'b0;
                    if (en && (pend_q || req)) st_d = ST_READ;
                    else if (!en)              st_d = ST_OFF;
                    else                       st_d = ST_IDLE;
                end else begin
                    pend_d = en & (pend_q | req);
                    st_d   = ST_READ;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        arm   = (st_q == ST_OFF) && en;
        rd_en = (st_q == ST_READ);
        wr_en = (st_q == ST_WRITE);
    end

    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en);

    // R8
    pending_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (rd_en || wr_en));

endmodule

// File: rtl/circ_dma_chan.sv
// Single circular-buffer DMA channel: memory words to a peripheral register.
module circ_dma_chan #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFF_W   = 16,
    parameter int MINOR_W = 16,
    parameter int MAJOR_W = 16,
    parameter int MOD_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               req,
    input  logic [ADDR_W-1:0]  cfg_src_base,
    input  logic [ADDR_W-1:0]  cfg_dst_addr,
    input  logic [OFF_W-1:0]   cfg_soff,
    input  logic [OFF_W-1:0]   cfg_doff,
    input  logic [MINOR_W-1:0] cfg_minor_bytes,
    input  logic [MAJOR_W-1:0] cfg_major_cnt,
    input  logic [MOD_W-1:0]   cfg_smod,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               per_wr_en,
    output logic [ADDR_W-1:0]  per_addr,
    output logic [DATA_W-1:0]  per_wdata,
    output logic               irq,
    output logic [ADDR_W-1:0]  pos
);

    localparam int BYTE_SH = $clog2(DATA_W / 8);

    logic               arm, rd_go, wr_go;
    logic               last_beat, last_minor, major_end;
    logic [MINOR_W-1:0] beats;
    logic [ADDR_W-1:0]  src_q, dst_q, src_nxt, dst_nxt;
    logic [ADDR_W-1:0]  pos_q, pos_sum, pos_nxt, blk_bytes, pos_keep;
    logic               irq_q;

    assign beats = cfg_minor_bytes >> BYTE_SH;

    dma_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .req       (req),
        .last_beat (last_beat),
        .arm       (arm),
        .rd_en     (rd_go),
        .wr_en     (wr_go)
    );

    dma_loop_ctr #(.MINOR_W(MINOR_W), .MAJOR_W(MAJOR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (arm),
        .step       (wr_go),
        .cfg_beats  (beats),
        .cfg_major  (cfg_major_cnt),
        .last_beat  (last_beat),
        .last_minor (last_minor)
    );

    dma_addr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MOD_W(MOD_W), .USE_MOD(1'b1)) u_src_step (
        .cur      (src_q),
        .step     (cfg_soff),
        .mod_bits (cfg_smod),
        .nxt      (src_nxt)
    );

    dma_addr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MOD_W(MOD_W), .USE_MOD(1'b0)) u_dst_step (
        .cur      (dst_q),
        .step     (cfg_doff),
        .mod_bits ('0),
        .nxt      (dst_nxt)
    );

    assign major_end = wr_go && last_beat && last_minor;
    assign blk_bytes = ADDR_W'(cfg_minor_bytes) * ADDR_W'(cfg_major_cnt);
    assign pos_sum   = pos_q + blk_bytes;
    assign pos_keep  = {ADDR_W{1'b1}} << cfg_smod;
    assign pos_nxt   = (cfg_smod == '0) ? pos_sum : (pos_sum & ~pos_keep);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (arm) begin
            src_q <= cfg_src_base;
            dst_q <= cfg_dst_addr;
        end else if (wr_go) begin
            src_q <= src_nxt;
            dst_q <= dst_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            pos_q <= '0;
        end else begin
            irq_q <= major_end;
            if (arm)            pos_q <= '0;
            else if (major_end) pos_q <= pos_nxt;
        end
    end

    assign mem_rd_en = rd_go;
    assign mem_addr  = src_q;
    assign per_wr_en = wr_go;
    assign per_addr  = dst_q;
    assign per_wdata = mem_rdata;
    assign irq       = irq_q;
    assign pos       = pos_q;

    // R4
    src_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && cfg_smod != '0) |->
        (((mem_addr ^ cfg_src_base) & ({ADDR_W{1'b1}} << cfg_smod)) == '0));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(per_wr_en));

endmodule

// File: tb/test_circ_dma_chan.sv
module test_circ_dma_chan;

    localparam int S_OFF = 0, S_IDLE = 1, S_READ = 2, S_WRITE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        req = 1'b0;
    logic [31:0] cfg_src_base = '0;
    logic [31:0] cfg_dst_addr = '0;
    logic [15:0] cfg_soff = '0;
    logic [15:0] cfg_doff = '0;
    logic [15:0] cfg_minor_bytes = 16'd4;
    logic [15:0] cfg_major_cnt = 16'd1;
    logic [4:0]  cfg_smod = '0;
    logic        mem_rd_en, per_wr_en, irq;
    logic [31:0] mem_addr, per_addr, per_wdata, pos;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int m_majors = 0;

    int          m_st = S_OFF;
    logic [31:0] m_src = '0, m_dst = '0, m_pos = '0;
    int          m_beat = 0, m_major = 0;
    bit          m_pend = 0, m_irq = 0;
    string       m_tag = "R1";

    circ_dma_chan i_circ_dma_chan (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .req             (req),
        .cfg_src_base    (cfg_src_base),
        .cfg_dst_addr    (cfg_dst_addr),
        .cfg_soff        (cfg_soff),
        .cfg_doff        (cfg_doff),
        .cfg_minor_bytes (cfg_minor_bytes),
        .cfg_major_cnt   (cfg_major_cnt),
        .cfg_smod        (cfg_smod),
        .mem_rd_en       (mem_rd_en),
        .mem_addr        (mem_addr),
        .mem_rdata       (mem_rdata),
        .per_wr_en       (per_wr_en),
        .per_addr        (per_addr),
        .per_wdata       (per_wdata),
        .irq             (irq),
        .pos             (pos)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] step_src(input logic [31:0] cur, input logic [15:0] s,
                                             input logic [4:0] k);
        logic [31:0] sum, win;
        sum = cur + {{16{s[15]}}, s};
        if (k == 0) return sum;
        win = (32'd1 << k) - 1;
        return (cur & ~win) | (sum & win);
    endfunction

    function automatic logic [31:0] wrap_pos(input logic [31:0] p, input logic [4:0] k);
        logic [31:0] sum;
        sum = p + cfg_minor_bytes * cfg_major_cnt;
        if (k == 0) return sum;
        return sum % (32'd1 << k);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory: returns the word for the address read in the previous cycle
    always @(negedge clk) begin
        if (rst_n && mem_rd_en) mem_rdata <= pat(mem_addr);
    end

    // cycle model built from the requirements
    always @(negedge clk) begin
        bit irq_n;
        irq_n = 0;
        if (!rst_n) begin
            m_st = S_OFF; m_pend = 0; m_irq = 0; m_pos = '0; m_tag = "R1";
        end else begin
            chk(mem_rd_en == (m_st == S_READ), m_tag, 32'(mem_rd_en), 32'(m_st == S_READ));
            chk(per_wr_en == (m_st == S_WRITE), "R2", 32'(per_wr_en), 32'(m_st == S_WRITE));
            if (m_st == S_READ)  chk(mem_addr == m_src, "R4", mem_addr, m_src);
            if (m_st == S_WRITE) begin
                chk(per_addr == m_dst, "R3", per_addr, m_dst);
                chk(per_wdata == pat(m_src), "R2", per_wdata, pat(m_src));
            end
            chk(irq == m_irq, "R5", 32'(irq), 32'(m_irq));
            chk(pos == m_pos, "R7", pos, m_pos);
            if (irq) irq_cnt++;
            case (m_st)
                S_OFF: begin
                    if (en) begin
                        m_st = S_IDLE; m_src = cfg_src_base; m_dst = cfg_dst_addr;
                        m_beat = int'(cfg_minor_bytes) / 4; m_major = int'(cfg_major_cnt);
                        m_pos = '0; m_tag = "R9";
                    end else m_tag = "R1";
                end
                S_IDLE: begin
                    if (!en)      begin m_st = S_OFF;  m_tag = "R9";  end
                    else if (req) begin m_st = S_READ; m_tag = "R10"; end
                    else m_tag = "R10";
                end
                S_READ: begin
                    m_pend = en && (m_pend || req);
                    m_st = S_WRITE; m_tag = "R2";
                end
                default: begin
                    m_src = step_src(m_src, cfg_soff, cfg_smod);
                    m_dst = m_dst + {{16{cfg_doff[15]}}, cfg_doff};
                    if (m_beat == 1) begin
                        m_beat = int'(cfg_minor_bytes) / 4;
                        if (m_major == 1) begin
                            m_major = int'(cfg_major_cnt);
                            irq_n = 1; m_majors++;
                            m_pos = wrap_pos(m_pos, cfg_smod);
                        end else m_major--;
                        if (en && (m_pend || req)) begin m_st = S_READ; m_tag = "R8"; end
                        else if (!en)              begin m_st = S_OFF;  m_tag = "R9"; end
                        else                       begin m_st = S_IDLE; m_tag = "R8"; end
                        m_pend = 0;
                    end else begin
                        m_beat--;
                        m_pend = en && (m_pend || req);
                        m_st = S_READ; m_tag = "R2";
                    end
                end
            endcase
        end
        m_irq = irq_n;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_req();
        req = 1'b1; tick(1); req = 1'b0;
    endtask

    task automatic shut_down();
        en = 1'b0; req = 1'b0; tick(200);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=%0d exp=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        @(negedge clk);
        // R1: reset state
        chk(!mem_rd_en && !per_wr_en, "R1", 32'(mem_rd_en | per_wr_en), 0);
        chk(irq == 1'b0, "R1", 32'(irq), 0);
        chk(pos == 32'd0, "R1", pos, 0);
        tick(0);
        // R1: requests while disabled are ignored
        pulse_req(); tick(2);
        @(negedge clk);
        chk(!mem_rd_en && !per_wr_en, "R1", 32'(mem_rd_en | per_wr_en), 0);

        // phase A: 64-byte window, 4 beats per request, 3 minors per major
        #1;
        cfg_src_base = 32'h0000_1240; cfg_dst_addr = 32'h4000_0020;
        cfg_soff = 16'd4; cfg_doff = 16'd0; cfg_minor_bytes = 16'd16;
        cfg_major_cnt = 16'd3; cfg_smod = 5'd6;
        en = 1'b1; tick(3);
        // R10: request in IDLE gives a read in the next cycle
        pulse_req();
        @(negedge clk);
        chk(mem_rd_en == 1'b1, "R10", 32'(mem_rd_en), 1);
        chk(mem_addr == 32'h0000_1240, "R9", mem_addr, 32'h0000_1240);
        tick(1);
        for (int i = 0; i < 600; i++) begin
            req = ($urandom % 4) == 0;
            tick(1);
        end
        req = 1'b0;
        tick(20);
        // R9: disable mid-loop
        pulse_req(); tick(2);
        en = 1'b0; pulse_req(); tick(30);
        @(negedge clk);
        chk(!mem_rd_en && !per_wr_en, "R9", 32'(mem_rd_en | per_wr_en), 0);
        #1;
        shut_down();

        // phase B: no modulo, stepping destination, random enable drops
        cfg_src_base = 32'h1000_0FF0; cfg_dst_addr = 32'h5000_0100;
        cfg_soff = 16'hFFF8; cfg_doff = 16'd4; cfg_minor_bytes = 16'd8;
        cfg_major_cnt = 16'd2; cfg_smod = 5'd0;
        en = 1'b1; tick(2);
        for (int i = 0; i < 800; i++) begin
            req = ($urandom % 3) == 0;
            if (($urandom % 60) == 0) en = ~en;
            tick(1);
        end
        shut_down();

        // phase C: 64-byte minors, 512 per major, 128 KiB window, request held high
        cfg_src_base = 32'h8006_0000; cfg_dst_addr = 32'h4002_0020;
        cfg_soff = 16'd4; cfg_doff = 16'd0; cfg_minor_bytes = 16'd64;
        cfg_major_cnt = 16'd512; cfg_smod = 5'd17;
        irq_cnt = 0; m_majors = 0;
        en = 1'b1; tick(2);
        req = 1'b1;
        for (int i = 0; i < 70000 && irq_cnt < 4; i++) tick(1);
        req = 1'b0;
        tick(2);
        // R6: counts reload and the channel keeps running
        chk(irq_cnt == 4, "R6", 32'(irq_cnt), 4);
        chk(m_majors == irq_cnt, "R6", 32'(irq_cnt), 32'(m_majors));
        // R7: four majors of 32 KiB fill the window exactly
        chk(pos == 32'd0, "R7", pos, 0);
        shut_down();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule